// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between an internal synchronous bus and an external asynchronous static RAM with a 17-bit address and an 8-bit data path. A single-word read or write request is accepted while the controller is idle. The controller then drives the address, the active-low chip select, write strobe and output enable, and the enable for the data-out driver. All timing comes from counting clock cycles.

Each wait count is the required time in nanoseconds divided by the clock period, rounded up, with a floor of one cycle. The write pulse has a floor of two cycles. The clock period and the RAM's speed-grade times are parameters.

On a read, chip select falls first. Output enable follows once the gap between the address access time and the output-enable access time has elapsed. The byte is sampled on the last cycle before both strobes rise, and the bus is then given time to float before the next cycle may begin.

On a write, output enable stays high throughout. The write strobe falls one cycle after chip select and rises one cycle before it, so the write ends on the write strobe's rising edge. A recovery gap follows before the next cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is asserted and right after it, ram_cs_n, ram_we_n and ram_oe_n are high, ram_dq_oe is 0, busy is 0 and done is 0.
- R2: A read accepted on clock edge E0 drives ram_cs_n low from E0 to E0+NR. NR = NCO+NOE, where NCO = max(1, ceil((T_ACC_NS-T_OACC_NS)/CLK_NS)) and NOE = max(ceil(T_OACC_NS/CLK_NS), ceil(T_ACC_NS/CLK_NS)-NCO). ram_oe_n is low from E0+NCO to E0+NR, and ram_we_n stays high throughout the read.
- R3: A read returns on rd_data the byte present on ram_dq_in during the last cycle of output enable. done is high for exactly the one cycle after edge E0+NR.
- R4: A write accepted on edge E0 holds ram_cs_n low from E0 to E0+NWP+2, where NWP = max(2, ceil(T_WP_NS/CLK_NS)). ram_we_n is low from E0+1 to E0+1+NWP, so the write strobe is low only while chip select is low. ram_addr stays unchanged while chip select is low.
- R5: ram_oe_n stays high during a whole write transfer.
- R6: ram_dq_oe rises one cycle after ram_we_n falls and falls one cycle after ram_we_n rises. The byte on ram_dq_out at the rising edge of ram_we_n is the request's write data.
- R7: done pulses for one cycle after edge E0+NWP+2 of a write, which is the cycle in which chip select rises.
- R8: After a read, busy stays high for NFL = max(1, ceil(max(T_CZ_NS,T_OZ_NS)/CLK_NS)) cycles, counted from the first done cycle, with chip select high and the data driver off. After a write, busy stays high for NRC = max(1, ceil(T_REC_NS/CLK_NS)) cycles counted the same way.
- R9: A request presented while busy is high is ignored: no extra transfer, no extra done, no RAM contents changed.
- R10: A request presented in the first cycle where busy is low is accepted on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Transfer or gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Captured read byte, valid with done |
| ram_addr | output | 17 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 8 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable of the data-out driver |
| ram_dq_in | input | 8 | Data from the RAM |

## Verification
A table of writes and reads runs against a small RAM model. It covers different address patterns, an all-zero byte, an all-ones byte, and an overwrite of a location already written. Each transfer is checked cycle by cycle for every strobe level, which separates an early or late output enable, write strobe or driver enable from the correct ordering.

Read-back values show whether data was stored on the right strobe edge with the right data. Directed cases cover reset, a request injected mid-transfer, and a request arriving exactly when busy drops. The gap lengths after reads and writes are measured against the float and recovery counts.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CS,
        ST_RD_OE,
        ST_RD_FLT,
        ST_WR_SET,
        ST_WR_PLS,
        ST_WR_HLD,
        ST_WR_REC
    } ctl_state_e;

    // ceiling of ns/clk, never below lo
    function automatic int wait_cyc(input int ns, input int clk, input int lo);
        int c;
        c = (ns + clk - 1) / clk;
        return (c < lo) ? lo : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_latch.sv
module sram_rd_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              wr_fin,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic [DATA_W-1:0] data_d, data_q;
    logic              done_d, done_q;

    always_comb begin
        data_d = cap_en ? din : data_q;
        done_d = cap_en | wr_fin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            data_q <= data_d;
            done_q <= done_d;
        end
    end

    assign rdata = data_q;
    assign done  = done_q;
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 10,
    parameter int T_ACC_NS   = 70,
    parameter int T_OACC_NS  = 35,
    parameter int T_CZ_NS    = 30,
    parameter int T_OZ_NS    = 20,
    parameter int T_WP_NS    = 55,
    parameter int T_REC_NS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    // wait counts derived from the speed grade
    localparam int NCO  = wait_cyc(T_ACC_NS - T_OACC_NS, CLK_NS, 1);
    localparam int NACC = wait_cyc(T_ACC_NS, CLK_NS, 1);
    localparam int NOA  = wait_cyc(T_OACC_NS, CLK_NS, 1);
    localparam int NOE  = (NOA > NACC - NCO) ? NOA : NACC - NCO;
    localparam int TZ   = (T_CZ_NS > T_OZ_NS) ? T_CZ_NS : T_OZ_NS;
    localparam int NFL  = wait_cyc(TZ, CLK_NS, 1);
    localparam int NWP  = wait_cyc(T_WP_NS, CLK_NS, 2);
    localparam int NRC  = wait_cyc(T_REC_NS, CLK_NS, 1);

    localparam logic [CNT_W-1:0] L_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] L_CO  = CNT_W'(NCO);
    localparam logic [CNT_W-1:0] L_OE  = CNT_W'(NOE);
    localparam logic [CNT_W-1:0] L_FL  = CNT_W'(NFL);
    localparam logic [CNT_W-1:0] L_WP  = CNT_W'(NWP);
    localparam logic [CNT_W-1:0] L_RC  = CNT_W'(NRC);

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_regs_t;

    ctl_regs_t        r_d, r_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_last;
    logic             cap_en;
    logic             wr_fin;

    sram_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    sram_rd_latch #(.DATA_W(DATA_W)) i_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .wr_fin (wr_fin),
        .din    (ram_dq_in),
        .rdata  (rd_data),
        .done   (done)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_val  = L_ONE;
        cap_en = 1'b0;
        wr_fin = 1'b0;
        // driver follows the write strobe by one cycle on both edges
        r_d.dq_oe = (r_q.st == ST_WR_PLS);
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.cs_n  = 1'b0;
                    t_load    = 1'b1;
                    if (req_write) begin
                        r_d.st = ST_WR_SET;
                        t_val  = L_ONE;
                    end else begin
                        r_d.st = ST_RD_CS;
                        t_val  = L_CO;
                    end
                end
            end
            ST_RD_CS: if (t_last) begin
                r_d.st   = ST_RD_OE;
                r_d.oe_n = 1'b0;
                t_load   = 1'b1;
                t_val    = L_OE;
            end
            ST_RD_OE: if (t_last) begin
                cap_en   = 1'b1;
                r_d.cs_n = 1'b1;
                r_d.oe_n = 1'b1;
                r_d.st   = ST_RD_FLT;
                t_load   = 1'b1;
                t_val    = L_FL;
            end
            ST_RD_FLT: if (t_last) r_d.st = ST_IDLE;
            ST_WR_SET: if (t_last) begin
                r_d.st   = ST_WR_PLS;
                r_d.we_n = 1'b0;
                t_load   = 1'b1;
                t_val    = L_WP;
            end
            ST_WR_PLS: if (t_last) begin
                r_d.we_n = 1'b1;
                r_d.st   = ST_WR_HLD;
                t_load   = 1'b1;
                t_val    = L_ONE;
            end
            ST_WR_HLD: if (t_last) begin
                r_d.cs_n = 1'b1;
                wr_fin   = 1'b1;
                r_d.st   = ST_WR_REC;
                t_load   = 1'b1;
                t_val    = L_RC;
            end
            ST_WR_REC: if (t_last) r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.cs_n  <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
            r_q.dq_oe <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign ram_addr   = r_q.addr;
    assign ram_cs_n   = r_q.cs_n;
    assign ram_we_n   = r_q.we_n;
    assign ram_oe_n   = r_q.oe_n;
    assign ram_dq_out = r_q.wdata;
    assign ram_dq_oe  = r_q.dq_oe;
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic              ram_dq_oe
);
    // R4
    we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_cs_n);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && !$past(ram_cs_n)) |-> $stable(ram_addr));
    // R5
    oe_off_in_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we_n || ram_dq_oe) |-> ram_oe_n);
    // R2
    oe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_oe_n |-> !ram_cs_n);
    // R6
    drv_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_dq_oe) |-> (!ram_we_n && !$past(ram_we_n)));
    // R6
    drv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_dq_oe) |-> (ram_we_n && $past(ram_we_n)));
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .ram_addr  (ram_addr),
    .ram_cs_n  (ram_cs_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;
    localparam int CLK_P = 10;
    // expected counts for the default speed grade, from the requirements
    localparam int NCO = 4;
    localparam int NR  = 8;
    localparam int NFL = 3;
    localparam int NWP = 6;
    localparam int NRC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done;
    logic [7:0]  rd_data, ram_dq_out, ram_dq_in;
    logic [16:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mem [64];

    always #(CLK_P/2) clk = ~clk;

    sram_strobe_ctrl i_sram_strobe_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .ram_addr(ram_addr), .ram_cs_n(ram_cs_n),
        .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    // small RAM model on the low address bits
    assign ram_dq_in = (!ram_cs_n && !ram_oe_n) ? mem[ram_addr[5:0]] : 8'h00;
    logic [7:0] last_wr;
    always @(posedge ram_we_n) begin
        if (rst_n && !ram_cs_n) begin
            n_chk++;
            if (!ram_dq_oe) begin
                n_bad++;
                $display("FAIL R6: driver off at write end, got %0b exp 1", ram_dq_oe);
            end
            mem[ram_addr[5:0]] = ram_dq_out;
            last_wr = ram_dq_out;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h exp %0h", req, act, exp);
        end
    endtask

    int t_done, t_free, t_bad, t_dones;

    // one transfer; inj injects an extra request while busy
    task automatic run(input logic wr, input logic [16:0] a, input logic [7:0] d, input logic inj);
        logic ecs, ewe, eoe, edq;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        t_done = 0; t_free = 0; t_bad = 0; t_dones = 0;
        for (int n = 1; n < 200; n++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (inj && n == 3) begin
                req_valid = 1'b1; req_write = 1'b1;
                req_addr = 17'h00004; req_wdata = 8'h99;
            end
            if (wr) begin
                ecs = !(n >= 1 && n <= NWP + 2);
                ewe = !(n >= 2 && n <= NWP + 1);
                eoe = 1'b1;
                edq = (n >= 3 && n <= NWP + 2);
            end else begin
                ecs = !(n >= 1 && n <= NR);
                ewe = 1'b1;
                eoe = !(n >= NCO + 1 && n <= NR);
                edq = 1'b0;
            end
            if (n < (wr ? NWP + 3 + NRC : NR + 1 + NFL))
                if (ram_cs_n !== ecs || ram_we_n !== ewe || ram_oe_n !== eoe || ram_dq_oe !== edq)
                    t_bad++;
            if (done) begin
                t_dones++;
                if (t_done == 0) t_done = n;
            end
            if (!busy) begin t_free = n; break; end
        end
        req_valid = 1'b0;
    endtask

    typedef logic [25:0] vec_t;   // {write, addr, data}
    localparam vec_t VEC [8] = '{
        {1'b1, 17'h00011, 8'hA5},
        {1'b1, 17'h1FF2A, 8'h3C},
        {1'b1, 17'h00005, 8'h00},
        {1'b0, 17'h00011, 8'hA5},
        {1'b0, 17'h1FF2A, 8'h3C},
        {1'b1, 17'h00011, 8'hFF},
        {1'b0, 17'h00011, 8'hFF},
        {1'b0, 17'h00005, 8'h00}
    };

    initial begin
        #(CLK_P * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got hang exp finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, busy, done}, 6'b111000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, busy, done}, 6'b111000);

        foreach (VEC[i]) begin
            run(VEC[i][25], VEC[i][24:8], VEC[i][7:0], 1'b0);
            if (VEC[i][25]) begin
                check("R4 R5 R6 strobe sequence", t_bad, 0);
                check("R7 write done cycle", t_done, NWP + 3);
                check("R6 stored byte", last_wr, VEC[i][7:0]);
                check("R8 write recovery", t_free - t_done, NRC);
            end else begin
                check("R2 strobe sequence", t_bad, 0);
                check("R3 read done cycle", t_done, NR + 1);
                check("R3 read byte", rd_data, VEC[i][7:0]);
                check("R8 read float gap", t_free - t_done, NFL);
            end
        end

        // R9: request during a write is dropped
        run(1'b1, 17'h00003, 8'h77, 1'b1);
        check("R9 single done", t_dones, 1);
        check("R9 strobes unchanged", t_bad, 0);
        run(1'b0, 17'h00004, 8'h00, 1'b0);
        check("R9 location untouched", rd_data, 8'h00);
        run(1'b0, 17'h00003, 8'h00, 1'b0);
        check("R9 first write kept", rd_data, 8'h77);

        // R10: request in the first idle cycle is taken at once
        run(1'b0, 17'h00011, 8'h00, 1'b0);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FF2A;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 back-to-back accept", {busy, ram_cs_n}, 2'b10);
        wait (done);
        @(negedge clk);
        check("R10 back-to-back data", rd_data, 8'h3C);
        wait (!busy);
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule